// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block sits beside a 16550-style UART register file and turns the raw interrupt conditions of the receiver, transmitter and modem lines into one prioritized 4-bit identification value and a single interrupt line. A 4-bit enable word gates five kinds of interrupt. One of these enable bits covers both receiver line status and the character timeout.

The receive-data and character-timeout conditions are levels, and the receive datapath owns them. The transmitter-empty, line-status and modem-status conditions arrive as one-cycle event pulses. Each pulse sets a sticky pending flag. Each flag is cleared by its own register access. Host software reads the identification value, services the reported source, and reads again until the value shows that nothing is pending.

Top module: `uart_irq_ident`

## Requirements
- R1: Enable bits: bit 0 enables received data, bit 1 enables transmitter empty, bit 2 enables receiver line status and character timeout, bit 3 enables modem status. A pending source whose bit is clear never appears in `iid` and never drives `irq`.
- R2: Codes on `iid`: 4'h6 for line status, 4'h4 for received data, 4'hC for character timeout, 4'h2 for transmitter empty, 4'h0 for modem status, and 4'h1 when nothing enabled is pending.
- R3: When several enabled sources are pending, `iid` reports the highest one. The order from highest to lowest is line status, received data, character timeout, transmitter empty, modem status.
- R4: `irq` is high exactly when `iid` is not 4'h1. `irq` is never high while all four enable bits are zero.
- R5: Character timeout is gated by enable bit 2 only. Bit 0 alone does not let it through.
- R6: A `rd_iid` strobe while `iid` is 4'h2 clears the transmitter-empty flag. A `rd_iid` strobe while another code is reported leaves that flag set.
- R7: A `thr_write` strobe clears the transmitter-empty flag.
- R8: A `line_err` pulse sets a sticky line-status flag. Only `rd_lsr` clears it.
- R9: A `modem_delta` pulse sets a sticky modem-status flag. Only `rd_msr` clears it.
- R10: When a set pulse and a clearing access for the same flag come in the same cycle, the flag ends up set.
- R11: After reset, every flag is clear, `iid` is 4'h1 and `irq` is low.
- R12: A flag is set even while its enable bit is clear. It appears in `iid` once the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_en | input | 4 | Interrupt enable word |
| rx_avail | input | 1 | Received data available or FIFO threshold reached (level) |
| rx_timeout | input | 1 | Character timeout (level) |
| thr_empty_set | input | 1 | Transmit holding register became empty (pulse) |
| thr_write | input | 1 | Transmit holding register written (pulse) |
| line_err | input | 1 | Line-status error summary event (pulse) |
| modem_delta | input | 1 | Modem-status delta summary event (pulse) |
| rd_iid | input | 1 | Identification register read strobe |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| iid | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt request |

## Verification
The bench steps the sources down the priority chain one at a time and checks each code. A design with a swapped encoder order would report the wrong code at that step. It reads the identification register while received data masks a pending transmitter-empty flag. A design that clears that flag on any read would lose the event. It drives a character timeout with only the received-data enable set. A design that gates timeout with bit 0 would show 4'hC there. It also sends set and clear in the same cycle, and it sets flags while their enable is off. A design that lets clear win, or that drops masked events, would then show 4'h1 where a code is expected.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int ID_W = 4;
  localparam int EN_W = 4;

  localparam logic [ID_W-1:0] ID_NONE  = 4'h1;
  localparam logic [ID_W-1:0] ID_LINE  = 4'h6;
  localparam logic [ID_W-1:0] ID_RXD   = 4'h4;
  localparam logic [ID_W-1:0] ID_TMO   = 4'hC;
  localparam logic [ID_W-1:0] ID_THR   = 4'h2;
  localparam logic [ID_W-1:0] ID_MODEM = 4'h0;

  // enable word bit positions
  localparam int EN_RXD   = 0;
  localparam int EN_THR   = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  // sticky flag indices
  localparam int FL_THR   = 0;
  localparam int FL_LINE  = 1;
  localparam int FL_MODEM = 2;
  localparam int NUM_FL   = 3;

  typedef struct packed {
    logic line;
    logic rxd;
    logic tmo;
    logic thr;
    logic modem;
  } irq_req_t;

  // mask raw requests by the enable word
  function automatic irq_req_t gate_req(input irq_req_t raw, input logic [EN_W-1:0] en);
    irq_req_t g;
    g.line  = raw.line  & en[EN_LINE];
    g.rxd   = raw.rxd   & en[EN_RXD];
    g.tmo   = raw.tmo   & en[EN_LINE];
    g.thr   = raw.thr   & en[EN_THR];
    g.modem = raw.modem & en[EN_MODEM];
    return g;
  endfunction

  // fixed-priority code selection
  function automatic logic [ID_W-1:0] pick_id(input irq_req_t g);
    if (g.line)       return ID_LINE;
    else if (g.rxd)   return ID_RXD;
    else if (g.tmo)   return ID_TMO;
    else if (g.thr)   return ID_THR;
    else if (g.modem) return ID_MODEM;
    else              return ID_NONE;
  endfunction

endpackage

// File: rtl/uart_irq_flags.sv
module uart_irq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_ev,
  output logic [N-1:0] pend
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend[i] <= 1'b0;
      else if (set_ev[i]) pend[i] <= 1'b1;   // set wins over clear
      else if (clr_ev[i]) pend[i] <= 1'b0;
    end

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> pend[i]);
    assert_clear_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ev[i] && !set_ev[i]) |=> !pend[i]);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_ev[i] && !set_ev[i]) |=> pend[i] == $past(pend[i]));
  end

endmodule

// File: rtl/uart_irq_prio_enc.sv
module uart_irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [EN_W-1:0]     en,
  input  irq_req_t            raw,
  output logic [ID_W-1:0]     id,
  output logic                req
);

  irq_req_t gated;

  always_comb begin
    gated = gate_req(raw, en);
    id    = pick_id(gated);
    req   = |gated;
  end

  assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (en != '0));
  assert_idle_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (id == ID_NONE) == !req);
  assert_rxd_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (id == ID_RXD) |-> (en[EN_RXD] && raw.rxd));
  assert_line_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (id == ID_LINE || id == ID_TMO) |-> en[EN_LINE]);
  assert_thr_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (id == ID_THR) |-> (en[EN_THR] && raw.thr));
  assert_modem_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (id == ID_MODEM) |-> (en[EN_MODEM] && raw.modem));
  assert_line_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (raw.line && en[EN_LINE]) |-> (id == ID_LINE));

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  irq_en,
  input  logic        rx_avail,
  input  logic        rx_timeout,
  input  logic        thr_empty_set,
  input  logic        thr_write,
  input  logic        line_err,
  input  logic        modem_delta,
  input  logic        rd_iid,
  input  logic        rd_lsr,
  input  logic        rd_msr,
  output logic [3:0]  iid,
  output logic        irq
);

  logic [NUM_FL-1:0] fl_set, fl_clr, fl_pend;
  logic              thr_ack;   // identification read that acknowledges the transmitter
  irq_req_t          raw;

  assign thr_ack = rd_iid && (iid == ID_THR);

  always_comb begin
    fl_set           = '0;
    fl_clr           = '0;
    fl_set[FL_THR]   = thr_empty_set;
    fl_clr[FL_THR]   = thr_write | thr_ack;
    fl_set[FL_LINE]  = line_err;
    fl_clr[FL_LINE]  = rd_lsr;
    fl_set[FL_MODEM] = modem_delta;
    fl_clr[FL_MODEM] = rd_msr;
  end

  uart_irq_flags #(.N(NUM_FL)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (fl_set),
    .clr_ev (fl_clr),
    .pend   (fl_pend)
  );

  always_comb begin
    raw.line  = fl_pend[FL_LINE];
    raw.rxd   = rx_avail;
    raw.tmo   = rx_timeout;
    raw.thr   = fl_pend[FL_THR];
    raw.modem = fl_pend[FL_MODEM];
  end

  uart_irq_prio_enc u_enc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (irq_en),
    .raw   (raw),
    .id    (iid),
    .req   (irq)
  );

  assert_thr_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_ack && !thr_empty_set) |=> (iid != ID_THR));
  assert_thr_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_write && !thr_empty_set) |=> !fl_pend[FL_THR]);
  assert_other_read_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iid && iid != ID_THR && fl_pend[FL_THR] && !thr_write) |=> fl_pend[FL_THR]);

endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] irq_en = '0;
  logic       rx_avail = 0, rx_timeout = 0, thr_empty_set = 0, thr_write = 0;
  logic       line_err = 0, modem_delta = 0, rd_iid = 0, rd_lsr = 0, rd_msr = 0;
  logic [3:0] iid;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;   // 125 MHz

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .rx_avail(rx_avail),
    .rx_timeout(rx_timeout), .thr_empty_set(thr_empty_set), .thr_write(thr_write),
    .line_err(line_err), .modem_delta(modem_delta), .rd_iid(rd_iid),
    .rd_lsr(rd_lsr), .rd_msr(rd_msr), .iid(iid), .irq(irq)
  );

  task automatic check(input string req, input logic [3:0] exp_id);
    logic exp_irq;
    exp_irq = (exp_id != 4'h1);
    n_chk++;
    if (iid !== exp_id || irq !== exp_irq) begin
      n_bad++;
      $display("FAIL %s: iid=%h irq=%b expected iid=%h irq=%b", req, iid, irq, exp_id, exp_irq);
    end
  endtask

  // one-cycle strobe; sampled on the negedge after the capturing posedge
  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    rx_avail = 0; rx_timeout = 0; irq_en = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset();
    irq_en = 4'hF;
    #1 check("R11 reset idle", 4'h1);
  endtask

  task automatic t_single_codes;
    do_reset();
    irq_en = 4'hF;
    pulse(modem_delta); check("R2 modem code", 4'h0);
    pulse(thr_empty_set); check("R2 thr code", 4'h2);
    @(negedge clk); rx_timeout = 1; #1 check("R2 timeout code", 4'hC);
    @(negedge clk); rx_avail = 1;   #1 check("R2 rxd code", 4'h4);
    pulse(line_err); check("R2 line code", 4'h6);
  endtask

  task automatic t_priority;
    // continues from all five pending
    pulse(rd_lsr); check("R3 rxd below line", 4'h4);
    @(negedge clk); rx_avail = 0;   #1 check("R3 timeout below rxd", 4'hC);
    @(negedge clk); rx_timeout = 0; #1 check("R3 thr below timeout", 4'h2);
    pulse(thr_write); check("R7 thr cleared by write", 4'h0);
    pulse(rd_msr); check("R9 modem cleared by msr read", 4'h1);
  endtask

  task automatic t_masking;
    do_reset();
    irq_en = 4'h0;
    pulse(line_err); pulse(modem_delta); pulse(thr_empty_set);
    @(negedge clk); rx_avail = 1; rx_timeout = 1;
    #1 check("R4 no enables no irq", 4'h1);
    @(negedge clk); irq_en = 4'b1000; #1 check("R12 modem flag kept while masked", 4'h0);
    @(negedge clk); irq_en = 4'b0010; #1 check("R1 thr only", 4'h2);
    @(negedge clk); irq_en = 4'b1011; #1 check("R1 line masked", 4'h4);
    @(negedge clk); rx_avail = 0; irq_en = 4'b0001; #1 check("R5 timeout not on bit0", 4'h1);
    @(negedge clk); irq_en = 4'b0100; #1 check("R5 line first under bit2", 4'h6);
    pulse(rd_lsr); check("R5 timeout under bit2", 4'hC);
    @(negedge clk); rx_timeout = 0; #1 check("R8 line cleared by lsr read", 4'h1);
  endtask

  task automatic t_thr_ack;
    do_reset();
    irq_en = 4'hF;
    pulse(thr_empty_set);
    @(negedge clk); rx_avail = 1; #1 check("R6 rxd masks thr", 4'h4);
    pulse(rd_iid); check("R6 read under rxd", 4'h4);
    @(negedge clk); rx_avail = 0; #1 check("R6 thr survives other read", 4'h2);
    pulse(rd_iid); check("R6 thr cleared by id read", 4'h1);
    pulse(rd_lsr); pulse(rd_msr); check("R8 R9 reads with nothing set", 4'h1);
  endtask

  task automatic t_set_wins;
    do_reset();
    irq_en = 4'hF;
    @(negedge clk); line_err = 1; rd_lsr = 1;
    @(negedge clk); line_err = 0; rd_lsr = 0;
    check("R10 line set beats lsr read", 4'h6);
    pulse(rd_lsr);
    @(negedge clk); modem_delta = 1; rd_msr = 1;
    @(negedge clk); modem_delta = 0; rd_msr = 0;
    check("R10 modem set beats msr read", 4'h0);
    @(negedge clk); thr_empty_set = 1; thr_write = 1;
    @(negedge clk); thr_empty_set = 0; thr_write = 0;
    pulse(rd_msr);
    check("R10 thr set beats write", 4'h2);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_single_codes();
        t_priority();
        t_masking();
        t_thr_ack();
        t_set_wins();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule